// File: doc/BRIEF.md
# Phase-Accumulator Baud Tick Generator

This block times the bit periods of a serial port. It has no integer divider. A 16-bit step value is added on every system clock into a 20-bit phase register. Each time the add overflows, the block raises a one-cycle bit tick. The average tick rate is therefore step × f_clk / 2^20, so fractional bit rates can be reached from any system clock without a baud-specific divider.

A second stage counts the ticks into ten-bit characters: one start bit, eight data bits and one stop bit. On every tenth tick it raises a character-done strobe, which the transmitter uses as its frame boundary. Software controls the block through one 32-bit control word. That word carries the step value and two enable bits. While neither enable bit is set, the phase register and the character count are held at zero.

Top module: `nco_baud_gen`

## Requirements
- R1: After reset the control word is 0, and `bit_tick` and `char_done` stay low for as long as no control write occurs.
- R2: A control write (`ctrl_wr` high at a clock edge) loads three fields: the step value from bits 31:16, the transmit enable from bit 0 and the receive enable from bit 1. Bits 15:2 have no effect on any output.
- R3: While either enable bit is set, every clock adds the step value to a 20-bit phase. Starting from a cleared phase, with step S the n-th clock edge after the enabling write edge produces a tick exactly when floor(n·S/2^20) > floor((n−1)·S/2^20). For example, step 0x8000 gives ticks at edges 32, 64, 96 and so on.
- R4: `bit_tick` is high for exactly one clock per phase overflow and is never high on two consecutive cycles.
- R5: A write that changes the step value while running does not clear the phase. The add at the write edge still uses the old step, and every later add uses the new one.
- R6: When both enable bits are clear, the phase and the character count are cleared, and `bit_tick` and `char_done` are low from the next cycle onward.
- R7: `char_done` is high for one cycle, in the same cycle as every tenth `bit_tick` counted since the block was last enabled, and never without a tick.
- R8: A step value of 0 with an enable bit set produces no ticks.
- R9: Setting only the receive enable bit produces the same tick timing as setting only the transmit enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: step value in 31:16, receive enable in bit 1, transmit enable in bit 0 |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| char_done | output | 1 | One-cycle pulse on every tenth bit tick |

## Verification
Two things can land on the same clock edge: a control write and a phase overflow. The bench writes a new step value on the exact edge where the first overflow is due, then checks two results. The tick from that edge must still appear, because it came from the old step. The next tick must arrive exactly 2^20/S_new cycles later, counted from a phase of zero. A second collision case disables the block on the edge of an overflow partway through a character. That tick must still appear. Ticks must then stop. After re-enabling, the character-done strobe must wait a full ten new ticks.

// File: rtl/nco_baud_pkg.sv
package nco_baud_pkg;

    localparam int CTRL_W       = 32;
    localparam int STEP_W       = 16;
    localparam int STEP_LSB     = 16;
    localparam int PHASE_W      = 20;
    localparam int FRAME_BITS   = 10;
    localparam int TX_ON_BIT    = 0;
    localparam int RX_ON_BIT    = 1;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              rx_on;
        logic              tx_on;
    } nco_cfg_t;

    localparam nco_cfg_t CFG_RESET = '{step: '0, rx_on: 1'b0, tx_on: 1'b0};

    function automatic nco_cfg_t unpack_ctrl(input logic [CTRL_W-1:0] word);
        nco_cfg_t c;
        c.step  = word[STEP_LSB +: STEP_W];
        c.rx_on = word[RX_ON_BIT];
        c.tx_on = word[TX_ON_BIT];
        return c;
    endfunction

    function automatic logic cfg_running(input nco_cfg_t c);
        return c.tx_on | c.rx_on;
    endfunction

endpackage

// File: rtl/nco_cfg_reg.sv
module nco_cfg_reg
    import nco_baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output nco_cfg_t          cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            cfg_q <= unpack_ctrl(wr_data);
        end
    end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int STEP_W  = 16,
    parameter int PHASE_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [STEP_W-1:0] step,
    output logic              carry,
    output logic              tick_q
);

    localparam int PAD_W = PHASE_W + 1 - STEP_W;

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W:0]   sum_w;

    // Widen both operands by one bit so the overflow lands in the top bit.
    assign sum_w = {1'b0, phase_q} + {{PAD_W{1'b0}}, step};
    assign carry = run & sum_w[PHASE_W];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
            tick_q  <= 1'b0;
        end else begin
            phase_q <= sum_w[PHASE_W-1:0];
            tick_q  <= sum_w[PHASE_W];
        end
    end

endmodule

// File: rtl/nco_frame_count.sv
module nco_frame_count #(
    parameter int FRAME_BITS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic advance,
    output logic done_q
);

    localparam int CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    assign at_last = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= advance & at_last;
            if (advance) begin
                cnt_q <= at_last ? '0 : cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/nco_baud_gen.sv
module nco_baud_gen
    import nco_baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic              bit_tick,
    output logic              char_done
);

    nco_cfg_t          cfg_q;
    logic              run_w;
    logic [STEP_W-1:0] step_w;
    logic              carry_w;

    nco_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl_wr),
        .wr_data (ctrl_wdata),
        .cfg_q   (cfg_q)
    );

    assign run_w  = cfg_running(cfg_q);
    assign step_w = cfg_q.step;

    nco_phase_acc #(
        .STEP_W  (STEP_W),
        .PHASE_W (PHASE_W)
    ) u_acc (
        .clk    (clk),
        .rst    (rst),
        .run    (run_w),
        .step   (step_w),
        .carry  (carry_w),
        .tick_q (bit_tick)
    );

    // The counter registers on the same edge as the tick,
    // so the two pulses line up in the same cycle.
    nco_frame_count #(
        .FRAME_BITS (FRAME_BITS)
    ) u_frame (
        .clk     (clk),
        .rst     (rst),
        .run     (run_w),
        .advance (carry_w),
        .done_q  (char_done)
    );

endmodule

// File: rtl/nco_baud_gen_chk.sv
module nco_baud_gen_chk #(
    parameter int STEP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic [STEP_W-1:0] step,
    input logic              bit_tick,
    input logic              char_done
);

    // R1: outputs are quiet right after a reset edge
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!bit_tick && !char_done));

    // R4: a tick never lasts two cycles
    a_r4_single_tick: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);

    // R6: no enable bit means no pulses on the following cycle
    a_r6_idle_silent: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!bit_tick && !char_done));

    // R7: the frame strobe only appears together with a tick
    a_r7_done_with_tick: assert property (@(posedge clk) disable iff (rst)
        char_done |-> bit_tick);

    // R8: a zero step while running yields no tick
    a_r8_zero_step: assert property (@(posedge clk) disable iff (rst)
        (run && step == '0) |=> !bit_tick);

endmodule

bind nco_baud_gen nco_baud_gen_chk #(
    .STEP_W (nco_baud_pkg::STEP_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run_w),
    .step      (step_w),
    .bit_tick  (bit_tick),
    .char_done (char_done)
);

// File: tb/nco_baud_gen_tb.sv
module nco_baud_gen_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = 32'h0;
    logic        bit_tick;
    logic        char_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Reference state derived from the requirements
    longint m_phase = 0;
    longint m_step  = 0;
    bit     m_run   = 0;
    int     m_cnt   = 0;
    bit     m_tick  = 0;
    bit     m_done  = 0;

    // Per-scenario observations
    int sc_steps, sc_ticks, sc_dones, sc_first_tick, sc_second_tick, sc_first_done;

    nco_baud_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .bit_tick   (bit_tick),
        .char_done  (char_done)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic scen_clear();
        sc_steps = 0; sc_ticks = 0; sc_dones = 0;
        sc_first_tick = -1; sc_second_tick = -1; sc_first_done = -1;
    endtask

    // One clock: optional write, model update at the edge, compare at the negedge.
    task automatic step(input bit wr, input logic [31:0] d, input string tag);
        ctrl_wr    = wr;
        ctrl_wdata = d;
        @(posedge clk);
        if (m_run) begin
            m_phase = m_phase + m_step;
            m_tick  = (m_phase >= 64'd1048576);
            m_phase = m_phase % 64'd1048576;
            m_done  = 0;
            if (m_tick) begin
                if (m_cnt == 9) begin m_done = 1; m_cnt = 0; end
                else m_cnt++;
            end
        end else begin
            m_phase = 0; m_cnt = 0; m_tick = 0; m_done = 0;
        end
        if (wr) begin
            m_step = longint'(d[31:16]);
            m_run  = d[0] | d[1];
        end
        @(negedge clk);
        ctrl_wr = 1'b0;
        sc_steps++;
        if (bit_tick) begin
            sc_ticks++;
            if (sc_first_tick < 0) sc_first_tick = sc_steps;
            else if (sc_second_tick < 0) sc_second_tick = sc_steps;
        end
        if (char_done) begin
            sc_dones++;
            if (sc_first_done < 0) sc_first_done = sc_steps;
        end
        check(bit_tick == m_tick, {tag, " bit_tick"}, bit_tick, m_tick);
        check(char_done == m_done, {tag, " char_done"}, char_done, m_done);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 32'h0, tag);
    endtask

    task automatic park();
        step(1'b1, 32'h0, "R6 park");
        idle(2, "R6 park");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(bit_tick == 1'b0, "R1 tick in reset", bit_tick, 0);
        check(char_done == 1'b0, "R1 done in reset", char_done, 0);
        rst = 1'b0;
        scen_clear();
        idle(200, "R1 idle");
        check(sc_ticks == 0, "R1 no ticks before write", sc_ticks, 0);
    endtask

    task automatic t_basic_rate();
        scen_clear();
        step(1'b1, 32'h8000_0001, "R3 enable");
        scen_clear();
        idle(320, "R3 run");
        check(sc_first_tick == 32, "R3 first tick edge", sc_first_tick, 32);
        check(sc_second_tick == 64, "R4 tick spacing", sc_second_tick, 64);
        check(sc_ticks == 10, "R3 tick count", sc_ticks, 10);
        check(sc_first_done == 320, "R7 tenth tick strobe", sc_first_done, 320);
        check(sc_dones == 1, "R7 strobe count", sc_dones, 1);
        park();
    endtask

    task automatic t_disable_midframe();
        step(1'b1, 32'h8000_0001, "R6 enable");
        idle(159, "R6 run");
        // Disable lands on the edge of the fifth overflow
        scen_clear();
        step(1'b1, 32'h8000_0000, "R6 disable");
        check(sc_ticks == 1, "R6 tick at disable edge", sc_ticks, 1);
        scen_clear();
        idle(100, "R6 off");
        check(sc_ticks == 0, "R6 silent while off", sc_ticks, 0);
        step(1'b1, 32'h8000_0001, "R6 reenable");
        scen_clear();
        idle(320, "R6 rerun");
        check(sc_first_tick == 32, "R6 phase cleared", sc_first_tick, 32);
        check(sc_first_done == 320, "R6 frame count cleared", sc_first_done, 320);
        park();
    endtask

    task automatic t_step_change();
        step(1'b1, 32'h8000_0001, "R5 enable");
        idle(16, "R5 run");
        scen_clear();
        step(1'b1, 32'h4000_0001, "R5 change");
        idle(40, "R5 run new");
        // 17 adds of 0x8000 then 30 adds of 0x4000 reach 2^20
        check(sc_first_tick == 31, "R5 phase kept", sc_first_tick, 31);
        park();
    endtask

    task automatic t_collision();
        step(1'b1, 32'h8000_0001, "R5 enable");
        idle(31, "R5 run");
        scen_clear();
        step(1'b1, 32'h2000_0001, "R5 write on overflow");
        check(sc_first_tick == 1, "R5 old step at write edge", sc_first_tick, 1);
        idle(130, "R5 run new");
        check(sc_second_tick == 129, "R5 new step after collision", sc_second_tick, 129);
        park();
    endtask

    task automatic t_enable_bits();
        step(1'b1, 32'h8000_0002, "R9 rx only");
        scen_clear();
        idle(40, "R9 run");
        check(sc_first_tick == 32, "R9 rx enable ticks", sc_first_tick, 32);
        park();
        step(1'b1, 32'h8000_FFFC, "R2 junk no enable");
        scen_clear();
        idle(100, "R2 off");
        check(sc_ticks == 0, "R2 low bits do not enable", sc_ticks, 0);
        step(1'b1, 32'h8000_7FFD, "R2 junk with tx");
        scen_clear();
        idle(64, "R2 run");
        check(sc_first_tick == 32, "R2 low bits ignored", sc_first_tick, 32);
        check(sc_ticks == 2, "R2 count with junk", sc_ticks, 2);
        park();
    endtask

    task automatic t_zero_and_max();
        step(1'b1, 32'h0000_0003, "R8 zero step");
        scen_clear();
        idle(300, "R8 run");
        check(sc_ticks == 0, "R8 zero step silent", sc_ticks, 0);
        park();
        step(1'b1, 32'hFFFF_0001, "R3 max step");
        scen_clear();
        idle(1000, "R3 max run");
        check(sc_first_tick == 17, "R3 max step first tick", sc_first_tick, 17);
        check(sc_ticks == 62, "R3 max step count", sc_ticks, 62);
        check(sc_dones == 6, "R7 max step strobes", sc_dones, 6);
        park();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_basic_rate();
        t_disable_midframe();
        t_step_change();
        t_collision();
        t_enable_bits();
        t_zero_and_max();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule